// File: doc/BRIEF.md
# Selectable Stream Flow-Control Wrapper

This block sits behind a streaming function that has one cycle of latency, such as a packet merger or splitter, and gives it backpressure on the output side. The function hands the wrapper two views of the same output stream. The first is its combinational next-state value. The second is that same value one cycle later, after the function's state register. The wrapper returns the stream towards the consumer and a ready/xon pair towards the function's producer. Both interfaces use a ready latency of one. A sink that raises ready in cycle t must accept any word that is valid in cycle t+1.

Two elaboration-time switches pick one of three variants:
- **Bypass.** Flow control is off. The registered view passes straight through, downstream ready is ignored, and upstream ready stays high.
- **Direct.** The combinational view goes through an output register that has one hold slot. Downstream ready passes combinationally to the producer.
- **Registered.** Downstream ready is captured in a flop first, the producer's ready also comes from a flop, and a small circular buffer absorbs the words still in flight.

Each word carries start, end and sync markers. These travel with the word and are qualified by valid. The xon level passes from consumer to producer unchanged in every variant.

Top module: `strm_flow_wrap`

## Requirements
- R1: In bypass (USE_READY=0) the registered view appears on the output in the same cycle, unchanged in data, valid and all three markers, whatever dn_ready does.
- R2: In bypass up_ready is 1 in every cycle, reset included.
- R3: up_xon equals dn_xon in the same cycle in every variant.
- R4: In the direct and registered variants, while rst is high, out_valid, out_sop, out_eop, out_sync and up_ready are all 0.
- R5: In the direct variant (USE_READY=1, PIPE_READY=0), up_ready equals dn_ready in the same cycle outside reset.
- R6: In both flow-controlled variants, out_valid is high in cycle t only if dn_ready was high in cycle t-1 (ready latency one).
- R7: In the direct variant, a word on the combinational view in cycle t is output in cycle t+1 when dn_ready is high in t. Otherwise it is held and output in the cycle after the next cycle in which dn_ready is high.
- R8: In the registered variant (USE_READY=1, PIPE_READY=1), words leave in arrival order, none lost or repeated. A held word is output in any cycle that follows a cycle with dn_ready high.
- R9: In the registered variant with HOLD_DEPTH of at least 3, a producer that sends whenever allowed and a consumer that is always ready give one output word per cycle after a short warm-up.
- R10: In the registered variant the buffer never holds more than HOLD_DEPTH words. With dn_ready held low it fills to exactly HOLD_DEPTH and then keeps up_ready low.
- R11: out_sop, out_eop and out_sync are low whenever out_valid is low. When valid, they equal the markers that entered with that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fn_nxt_data | input | DATA_W | Combinational next-state data from the function |
| fn_nxt_valid | input | 1 | Combinational next-state valid |
| fn_nxt_sop | input | 1 | Combinational next-state start marker |
| fn_nxt_eop | input | 1 | Combinational next-state end marker |
| fn_nxt_sync | input | 1 | Combinational next-state sync marker |
| fn_reg_data | input | DATA_W | Registered data from the function |
| fn_reg_valid | input | 1 | Registered valid |
| fn_reg_sop | input | 1 | Registered start marker |
| fn_reg_eop | input | 1 | Registered end marker |
| fn_reg_sync | input | 1 | Registered sync marker |
| dn_ready | input | 1 | Ready from the consumer, latency one |
| dn_xon | input | 1 | Transmit-on level from the consumer |
| out_data | output | DATA_W | Output data |
| out_valid | output | 1 | Output valid |
| out_sop | output | 1 | Output start marker |
| out_eop | output | 1 | Output end marker |
| out_sync | output | 1 | Output sync marker |
| up_ready | output | 1 | Ready towards the function's producer, latency one |
| up_xon | output | 1 | Transmit-on level towards the producer |

## Verification
The hardest state to reach is the registered variant with its buffer full and upstream ready already withdrawn. At that point words the producer was allowed to send two cycles earlier are still arriving. The bench gets there by first running a fully ready, fully loaded stream, then holding dn_ready low while the producer keeps sending whenever it is allowed. The model queue must then settle at exactly HOLD_DEPTH entries. After that, a drain phase with ready high must return every held word in order. All three variants run side by side from one shared ready pattern, each with its own producer that obeys that variant's up_ready of the previous cycle.

// File: rtl/strm_flow_pkg.sv
package strm_flow_pkg;

   typedef enum logic [1:0] {
      FC_BYPASS     = 2'd0,
      FC_DIRECT     = 2'd1,
      FC_REGISTERED = 2'd2
   } fc_mode_e;

   localparam int MARK_W = 3;

   typedef struct packed {
      logic sync;
      logic sop;
      logic eop;
   } strm_mark_t;

   function automatic fc_mode_e pick_mode(input bit use_ready, input bit pipe_ready);
      if (!use_ready) return FC_BYPASS;
      return pipe_ready ? FC_REGISTERED : FC_DIRECT;
   endfunction

endpackage

// File: rtl/strm_hold_stage.sv
// Output register with one hold slot; downstream ready passes straight upstream.
module strm_hold_stage #(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [WORD_W-1:0] in_word,
   input  logic              in_valid,
   input  logic              dn_ready,
   output logic [WORD_W-1:0] out_word,
   output logic              out_valid,
   output logic              up_ready
);

   logic [WORD_W-1:0] held_word;
   logic [WORD_W-1:0] pend_word;
   logic              held_valid;
   logic              pend_valid;

   // Oldest word first: a held word is only present when no new word can arrive.
   assign pend_valid = in_valid || held_valid;
   assign pend_word  = in_valid ? in_word : held_word;
   assign up_ready   = dn_ready && !rst;

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid  <= 1'b0;
         held_valid <= 1'b0;
      end else if (dn_ready) begin
         out_valid  <= pend_valid;
         held_valid <= 1'b0;
      end else begin
         out_valid  <= 1'b0;
         held_valid <= pend_valid;
      end
   end

   always_ff @(posedge clk) begin
      if (dn_ready) begin
         out_word <= pend_word;
      end else begin
         held_word <= pend_word;
      end
   end

endmodule

// File: rtl/strm_skid_fifo.sv
// Circular buffer with captured downstream ready and a registered upstream ready.
module strm_skid_fifo #(
   parameter int WORD_W = 8,
   parameter int DEPTH  = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [WORD_W-1:0] in_word,
   input  logic              in_valid,
   input  logic              dn_ready,
   output logic [WORD_W-1:0] out_word,
   output logic              out_valid,
   output logic              up_ready
);

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);

   logic [WORD_W-1:0] slot [DEPTH];
   logic [PTR_W-1:0]  wr_ptr;
   logic [PTR_W-1:0]  rd_ptr;
   logic [CNT_W-1:0]  count;
   logic [CNT_W-1:0]  count_d;
   logic              rdy_q;
   logic              push;
   logic              pop;
   logic              up_ready_d;

   function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign pop     = rdy_q && (count != '0);
   assign push    = in_valid && (pop || (count != CNT_W'(DEPTH)));
   assign count_d = count + CNT_W'(push) - CNT_W'(pop);

   // Reserve room for the word already granted and the one a new grant allows.
   assign up_ready_d = (int'(count_d) + int'(up_ready) + 1) <= DEPTH;

   assign out_valid = pop;
   assign out_word  = slot[rd_ptr];

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr   <= '0;
         rd_ptr   <= '0;
         count    <= '0;
         rdy_q    <= 1'b0;
         up_ready <= 1'b0;
      end else begin
         if (push) wr_ptr <= bump(wr_ptr);
         if (pop)  rd_ptr <= bump(rd_ptr);
         count    <= count_d;
         rdy_q    <= dn_ready;
         up_ready <= up_ready_d;
      end
   end

   always_ff @(posedge clk) begin
      if (push) slot[wr_ptr] <= in_word;
   end

endmodule

// File: rtl/strm_flow_wrap.sv
module strm_flow_wrap
   import strm_flow_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter bit USE_READY  = 1'b1,
   parameter bit PIPE_READY = 1'b1,
   parameter int HOLD_DEPTH = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] fn_nxt_data,
   input  logic              fn_nxt_valid,
   input  logic              fn_nxt_sop,
   input  logic              fn_nxt_eop,
   input  logic              fn_nxt_sync,
   input  logic [DATA_W-1:0] fn_reg_data,
   input  logic              fn_reg_valid,
   input  logic              fn_reg_sop,
   input  logic              fn_reg_eop,
   input  logic              fn_reg_sync,
   input  logic              dn_ready,
   input  logic              dn_xon,
   output logic [DATA_W-1:0] out_data,
   output logic              out_valid,
   output logic              out_sop,
   output logic              out_eop,
   output logic              out_sync,
   output logic              up_ready,
   output logic              up_xon
);

   localparam fc_mode_e MODE   = pick_mode(USE_READY, PIPE_READY);
   localparam int       WORD_W = DATA_W + MARK_W;

   logic [WORD_W-1:0] nxt_word;
   logic [WORD_W-1:0] reg_word;
   logic [WORD_W-1:0] st_word;
   logic              st_valid;
   logic              st_up_ready;
   strm_mark_t        st_mark;

   assign nxt_word = {fn_nxt_sync, fn_nxt_sop, fn_nxt_eop, fn_nxt_data};
   assign reg_word = {fn_reg_sync, fn_reg_sop, fn_reg_eop, fn_reg_data};

   if (DATA_W < 1) begin : g_bad_width
      $error("strm_flow_wrap: DATA_W must be at least 1");
   end
   if (MODE == FC_REGISTERED && HOLD_DEPTH < 2) begin : g_bad_depth
      $error("strm_flow_wrap: HOLD_DEPTH must be at least 2 in registered mode");
   end

   case (MODE)
      FC_BYPASS: begin : g_bypass
         logic unused_bypass;
         assign unused_bypass = ^{nxt_word, fn_nxt_valid, dn_ready, clk, rst};
         assign st_word     = reg_word;
         assign st_valid    = fn_reg_valid;
         assign st_up_ready = 1'b1;
      end
      FC_DIRECT: begin : g_direct
         logic unused_direct;
         assign unused_direct = ^{reg_word, fn_reg_valid};
         strm_hold_stage #(
            .WORD_W (WORD_W)
         ) i_hold (
            .clk       (clk),
            .rst       (rst),
            .in_word   (nxt_word),
            .in_valid  (fn_nxt_valid),
            .dn_ready  (dn_ready),
            .out_word  (st_word),
            .out_valid (st_valid),
            .up_ready  (st_up_ready)
         );
      end
      default: begin : g_registered
         logic unused_registered;
         assign unused_registered = ^{reg_word, fn_reg_valid};
         strm_skid_fifo #(
            .WORD_W (WORD_W),
            .DEPTH  (HOLD_DEPTH)
         ) i_skid (
            .clk       (clk),
            .rst       (rst),
            .in_word   (nxt_word),
            .in_valid  (fn_nxt_valid),
            .dn_ready  (dn_ready),
            .out_word  (st_word),
            .out_valid (st_valid),
            .up_ready  (st_up_ready)
         );
      end
   endcase

   assign st_mark   = strm_mark_t'(st_word[WORD_W-1:DATA_W]);
   assign out_data  = st_word[DATA_W-1:0];
   assign out_valid = st_valid;
   assign out_sop   = st_valid & st_mark.sop;
   assign out_eop   = st_valid & st_mark.eop;
   assign out_sync  = st_valid & st_mark.sync;
   assign up_ready  = st_up_ready;
   assign up_xon    = dn_xon;

endmodule

// File: rtl/strm_flow_wrap_chk.sv
module strm_flow_wrap_chk #(
   parameter bit USE_READY  = 1'b1,
   parameter bit PIPE_READY = 1'b1,
   parameter int HOLD_DEPTH = 3
) (
   input logic clk,
   input logic rst,
   input logic nxt_valid,
   input logic dn_ready,
   input logic out_valid,
   input logic up_ready
);

   logic unused_chk;
   assign unused_chk = ^{nxt_valid, dn_ready, out_valid, up_ready};

   if (USE_READY) begin : g_fc
      // R6: output valid only after a ready cycle
      p_rl_one_r6 : assert property (@(posedge clk) disable iff (rst)
         out_valid |-> $past(dn_ready));

      // R6: the producer side keeps the same one-cycle ready latency
      p_src_obeys_r6 : assert property (@(posedge clk) disable iff (rst)
         nxt_valid |-> $past(up_ready));

      if (!PIPE_READY) begin : g_direct
         // R7: a word arriving while ready is high leaves in the next cycle
         p_direct_issue_r7 : assert property (@(posedge clk) disable iff (rst)
            $past(dn_ready && nxt_valid) |-> out_valid);
      end else begin : g_registered
         logic [7:0] occ;
         always_ff @(posedge clk) begin
            if (rst) occ <= 8'd0;
            else     occ <= occ + 8'(nxt_valid) - 8'(out_valid);
         end

         // R10: occupancy stays within the buffer depth
         p_no_overflow_r10 : assert property (@(posedge clk) disable iff (rst)
            occ <= 8'(HOLD_DEPTH));

         // R8: a held word is issued after any ready cycle
         p_issue_held_r8 : assert property (@(posedge clk) disable iff (rst)
            (occ != 8'd0) && $past(dn_ready) |-> out_valid);
      end
   end

endmodule

bind strm_flow_wrap strm_flow_wrap_chk #(
   .USE_READY  (USE_READY),
   .PIPE_READY (PIPE_READY),
   .HOLD_DEPTH (HOLD_DEPTH)
) i_strm_flow_wrap_chk (
   .clk       (clk),
   .rst       (rst),
   .nxt_valid (fn_nxt_valid),
   .dn_ready  (dn_ready),
   .out_valid (out_valid),
   .up_ready  (up_ready)
);

// File: tb/test_strm_flow_wrap.sv
module test_strm_flow_wrap;

   localparam int CLK_PERIOD = 10;
   localparam int DW         = 8;
   localparam int DEPTH      = 3;

   logic clk = 1'b0;
   logic rst;
   logic dn_ready;
   logic dn_xon;

   logic [DW-1:0] nxt_d [3];
   logic [DW-1:0] reg_d [3];
   logic [DW-1:0] out_d [3];
   logic nxt_v [3], nxt_sop [3], nxt_eop [3], nxt_sync [3];
   logic reg_v [3], reg_sop [3], reg_eop [3], reg_sync [3];
   logic out_v [3], out_sop [3], out_eop [3], out_sync [3];
   logic upr [3], upx [3];

   always #(CLK_PERIOD/2) clk = ~clk;

   // mode 0: bypass, mode 1: direct, mode 2: registered
   for (genvar m = 0; m < 3; m++) begin : g_mode
      strm_flow_wrap #(
         .DATA_W     (DW),
         .USE_READY  (m != 0),
         .PIPE_READY (m == 2),
         .HOLD_DEPTH (DEPTH)
      ) i_strm_flow_wrap (
         .clk          (clk),
         .rst          (rst),
         .fn_nxt_data  (nxt_d[m]),
         .fn_nxt_valid (nxt_v[m]),
         .fn_nxt_sop   (nxt_sop[m]),
         .fn_nxt_eop   (nxt_eop[m]),
         .fn_nxt_sync  (nxt_sync[m]),
         .fn_reg_data  (reg_d[m]),
         .fn_reg_valid (reg_v[m]),
         .fn_reg_sop   (reg_sop[m]),
         .fn_reg_eop   (reg_eop[m]),
         .fn_reg_sync  (reg_sync[m]),
         .dn_ready     (dn_ready),
         .dn_xon       (dn_xon),
         .out_data     (out_d[m]),
         .out_valid    (out_v[m]),
         .out_sop      (out_sop[m]),
         .out_eop      (out_eop[m]),
         .out_sync     (out_sync[m]),
         .up_ready     (upr[m]),
         .up_xon       (upx[m])
      );
   end

   int  n_checks = 0;
   int  n_fail   = 0;
   bit  finished = 0;
   int  qd[$];
   int  qr[$];
   int  next_val [3];
   bit  upr_prev [3];
   bit  prev_dnr;
   bit  dir_exp_v;
   int  dir_exp_d;
   int  tp_count;
   bit  tp_on;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // {sync, sop, eop} for a word: start every 4, end every 4 offset 3, sync every 16
   function automatic logic [2:0] marks_of(input bit v, input int d);
      if (!v) return 3'b000;
      return {d % 16 == 0, d % 4 == 0, d % 4 == 3};
   endfunction

   task automatic run_cycle(input int rdy_pct, input int send_pct);
      bit rdy;
      bit xon;
      bit sent [3];
      bit exp2v;
      int exp2d;
      logic [2:0] mk;
      @(posedge clk);
      #1;
      rdy = ($urandom_range(99) < rdy_pct);
      xon = 1'($urandom_range(1));
      dn_ready = rdy;
      dn_xon   = xon;
      for (int m = 0; m < 3; m++) begin
         reg_d[m]    = nxt_d[m];
         reg_v[m]    = nxt_v[m];
         reg_sop[m]  = nxt_sop[m];
         reg_eop[m]  = nxt_eop[m];
         reg_sync[m] = nxt_sync[m];
         sent[m] = upr_prev[m] && ($urandom_range(99) < send_pct);
         if (sent[m]) begin
            mk          = marks_of(1'b1, next_val[m]);
            nxt_d[m]    = DW'(next_val[m]);
            nxt_v[m]    = 1'b1;
            nxt_sync[m] = mk[2];
            nxt_sop[m]  = mk[1];
            nxt_eop[m]  = mk[0];
            next_val[m] = (next_val[m] + 1) % 256;
         end else begin
            nxt_v[m]    = 1'b0;
            nxt_sync[m] = 1'b0;
            nxt_sop[m]  = 1'b0;
            nxt_eop[m]  = 1'b0;
         end
      end
      @(negedge clk);
      // R1 / R2: bypass follows the registered view
      chk(out_v[0] == reg_v[0] && out_d[0] == reg_d[0] && out_sop[0] == reg_sop[0]
          && out_eop[0] == reg_eop[0] && out_sync[0] == reg_sync[0],
          "R1 bypass pass-through", int'(out_d[0]), int'(reg_d[0]));
      chk(upr[0] == 1'b1, "R2 bypass up_ready", int'(upr[0]), 1);
      // R3: xon in every variant
      for (int m = 0; m < 3; m++) chk(upx[m] == xon, "R3 xon", int'(upx[m]), int'(xon));
      // R5: direct ready follows downstream
      chk(upr[1] == rdy, "R5 direct up_ready", int'(upr[1]), int'(rdy));
      // R6: ready latency one
      for (int m = 1; m < 3; m++)
         chk(!out_v[m] || prev_dnr, "R6 valid after ready", int'(out_v[m]), 0);
      // R7: direct exact output
      chk(out_v[1] == dir_exp_v && (!dir_exp_v || out_d[1] == DW'(dir_exp_d)),
          "R7 direct word", out_v[1] ? int'(out_d[1]) : -1, dir_exp_v ? dir_exp_d : -1);
      mk = marks_of(dir_exp_v, dir_exp_d);
      chk({out_sync[1], out_sop[1], out_eop[1]} == mk, "R11 direct markers",
          int'({out_sync[1], out_sop[1], out_eop[1]}), int'(mk));
      if (sent[1]) qd.push_back(int'(nxt_d[1]));
      if (rdy && qd.size() > 0) begin
         dir_exp_v = 1'b1;
         dir_exp_d = qd.pop_front();
      end else begin
         dir_exp_v = 1'b0;
      end
      // R8: registered exact output
      exp2v = (qr.size() > 0) && prev_dnr;
      exp2d = exp2v ? qr[0] : -1;
      chk(out_v[2] == exp2v && (!exp2v || out_d[2] == DW'(exp2d)),
          "R8 registered word", out_v[2] ? int'(out_d[2]) : -1, exp2d);
      mk = marks_of(exp2v, exp2d);
      chk({out_sync[2], out_sop[2], out_eop[2]} == mk, "R11 registered markers",
          int'({out_sync[2], out_sop[2], out_eop[2]}), int'(mk));
      if (exp2v) void'(qr.pop_front());
      if (sent[2]) qr.push_back(int'(nxt_d[2]));
      chk(qr.size() <= DEPTH, "R10 occupancy bound", qr.size(), DEPTH);
      if (tp_on && out_v[2]) tp_count++;
      for (int m = 0; m < 3; m++) upr_prev[m] = upr[m];
      prev_dnr = rdy;
   endtask

   initial begin
      rst      = 1'b1;
      dn_ready = 1'b0;
      dn_xon   = 1'b0;
      for (int m = 0; m < 3; m++) begin
         nxt_d[m] = '0; nxt_v[m] = 1'b0; nxt_sop[m] = 1'b0; nxt_eop[m] = 1'b0; nxt_sync[m] = 1'b0;
         reg_d[m] = '0; reg_v[m] = 1'b0; reg_sop[m] = 1'b0; reg_eop[m] = 1'b0; reg_sync[m] = 1'b0;
         next_val[m] = 0;
      end
      prev_dnr  = 1'b0;
      dir_exp_v = 1'b0;
      dir_exp_d = 0;
      tp_count  = 0;
      tp_on     = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R4: reset state in the flow-controlled variants
      for (int m = 1; m < 3; m++) begin
         chk(!out_v[m] && !out_sop[m] && !out_eop[m] && !out_sync[m],
             "R4 reset outputs", int'(out_v[m]), 0);
         chk(!upr[m], "R4 reset up_ready", int'(upr[m]), 0);
      end
      chk(upr[0] == 1'b1, "R2 bypass up_ready in reset", int'(upr[0]), 1);
      for (int m = 0; m < 3; m++) upr_prev[m] = upr[m];
      rst = 1'b0;

      // random ready and random producer
      repeat (400) run_cycle(60, 75);

      // full load, always ready: R9 throughput
      repeat (10) run_cycle(100, 100);
      tp_on = 1'b1;
      repeat (50) run_cycle(100, 100);
      tp_on = 1'b0;
      chk(tp_count == 50, "R9 registered throughput", tp_count, 50);

      // consumer halted, producer keeps trying: R10 fill and stall
      repeat (30) run_cycle(0, 100);
      chk(qr.size() == DEPTH, "R10 fills to depth", qr.size(), DEPTH);
      chk(upr[2] == 1'b0, "R10 up_ready held low", int'(upr[2]), 0);
      chk(qd.size() + int'(dir_exp_v) <= 1, "R7 single held word", qd.size(), 1);

      // drain: R8 / R7 nothing lost
      repeat (30) run_cycle(100, 0);
      chk(qr.size() == 0, "R8 registered drained", qr.size(), 0);
      chk(qd.size() == 0 && !dir_exp_v, "R7 direct drained", qd.size(), 0);
      chk(upr[2] == 1'b1, "R10 up_ready recovers", int'(upr[2]), 1);

      // a further random stretch with sparse ready
      repeat (150) run_cycle(30, 90);
      repeat (20) run_cycle(100, 0);
      chk(qr.size() == 0 && qd.size() == 0, "R8 final drain", qr.size() + qd.size(), 0);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 50000);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

endmodule